// File: doc/BRIEF.md
# SMM and Suspend State Sequencer

This block is the control state machine that tracks where a processor core stands among four conditions: ordinary software, interrupt service, system management mode (SMM) and suspend. It takes single-cycle strobes from instruction execution for halt, interrupt return, SMM resume and software SMM entry. It also takes an active-low suspend request pin, an active-low SMI pin, an NMI line, an INTR line and the interrupt-enable flag. From these it produces the current state code, an active-low suspend acknowledge, an SMM-active flag, and one dispatch strobe each for SMI, NMI and INTR service.

Suspend can be entered in two ways, and each has its own exit rule. A halt-entered suspend wakes as soon as a serviceable request arrives. A pin-entered suspend holds one occurrence of each request source and releases nothing until the pin goes high again. Every request passes through one pending latch. A priority arbiter drains that latch one request per cycle, and only in states where that source may be serviced. The same latch therefore defers NMI and INTR while the core is in SMM.

Top module: `smm_susp_seq`

## Requirements
- R1: After reset the state code is 0 (normal), suspend acknowledge is high, the SMM flag is low, no dispatch strobe is high, and no request is pending.
- R2: State codes are 0 normal, 1 interrupt service, 2 halt suspend (normal context), 3 pin suspend (normal context), 4 SMM, 5 halt suspend (SMM context), 6 pin suspend (SMM context), 7 interrupt service inside SMM. A halt strobe moves state 0 to 2 and state 4 to 5.
- R3: Suspend acknowledge is low in states 2, 3, 5 and 6 and high in every other state. The SMM flag is high in states 4 to 7.
- R4: In state 2 an SMI request produces the SMI dispatch strobe for one cycle. The next state is 4.
- R5: In state 2 an NMI or INTR request dispatches and moves the machine to state 1. In state 5 the same requests move it to state 7. An interrupt-return strobe moves state 1 to 0 and state 7 to 4.
- R6: When the synchronized suspend pin is low, states 0 and 1 go to state 3 and states 4 and 7 go to state 6. When the pin goes high again, the machine returns to the state it left.
- R7: Requests that arrive during pin suspend or during SMM are held. Each source holds at most one occurrence, so repeated requests from the same source produce a single dispatch.
- R8: INTR is captured only in a cycle where intr_i and if_i are both high. NMI is captured whatever if_i is.
- R9: Dispatch fires at most one strobe per cycle, with priority SMI, then NMI, then INTR. SMI, NMI and INTR may dispatch in states 0, 1 and 2, and NMI and INTR may also dispatch in state 5. A dispatch clears that source's pending bit. An SMI dispatch moves to state 4, and an NMI or INTR dispatch from state 0 moves to state 1.
- R10: A software SMM entry strobe in state 0 moves to state 4 with no SMI strobe. A resume strobe in state 4 moves to state 0.
- R11: The SMI, suspend and NMI pins pass through two synchronizer flops. A falling edge on SMI and a rising edge on NMI each count as one request. A pin change reaches the state code or a strobe three clock edges after it is applied. An INTR request shows on its strobe one edge after capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hlt_i | input | 1 | Halt instruction strobe |
| iret_i | input | 1 | Interrupt return strobe |
| rsm_i | input | 1 | SMM resume strobe |
| smint_i | input | 1 | Software SMM entry strobe |
| susp_ni | input | 1 | Suspend request pin, active low, asynchronous |
| smi_ni | input | 1 | SMI pin, active low, asynchronous |
| nmi_i | input | 1 | NMI pin, asynchronous, rising edge |
| intr_i | input | 1 | Maskable interrupt request, synchronous |
| if_i | input | 1 | Interrupt-enable flag |
| state_o | output | 3 | Current state code |
| suspa_no | output | 1 | Suspend acknowledge, active low |
| smm_o | output | 1 | SMM context active |
| smi_disp_o | output | 1 | SMI dispatch strobe |
| nmi_disp_o | output | 1 | NMI dispatch strobe |
| intr_disp_o | output | 1 | INTR dispatch strobe |

## Verification
The assertions assume that the instruction strobes come from the core's own execution. They therefore assume at most one such strobe per cycle, and only in a state where that instruction can execute. The assertions also assume that the asynchronous pins stay at each level for at least one full clock period, so that the synchronizers see every edge. The directed stimulus respects both assumptions. It changes inputs only on the falling clock edge, pulses each instruction strobe for exactly one cycle and only in a state that accepts it, and holds each pin level across at least one rising edge.

// File: rtl/smm_susp_pkg.sv
`timescale 1ns/1ps
package smm_susp_pkg;
  typedef enum logic [2:0] {
    ST_NORM    = 3'd0,
    ST_ISR     = 3'd1,
    ST_HALT_N  = 3'd2,
    ST_PSUSP_N = 3'd3,
    ST_SMM     = 3'd4,
    ST_HALT_S  = 3'd5,
    ST_PSUSP_S = 3'd6,
    ST_ISR_S   = 3'd7
  } seq_state_e;

  localparam int unsigned REQ_N    = 3;
  localparam int unsigned REQ_SMI  = 0;
  localparam int unsigned REQ_NMI  = 1;
  localparam int unsigned REQ_INTR = 2;
endpackage

// File: rtl/smm_pin_sync.sv
`timescale 1ns/1ps
module smm_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned TOP = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= {STAGES{RST_VAL[b]}};
      else         sh_q <= {sh_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh_q[TOP];
  end
endmodule

// File: rtl/smm_req_latch.sv
`timescale 1ns/1ps
module smm_req_latch
  import smm_susp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smi_n_s_i,
  input  logic             nmi_s_i,
  input  logic             intr_i,
  input  logic             if_i,
  input  logic [REQ_N-1:0] clr_i,
  output logic [REQ_N-1:0] pend_o
);
  logic             smi_n_q, nmi_q;
  logic [REQ_N-1:0] set_d, pend_q;

  always_comb begin
    set_d           = '0;
    set_d[REQ_SMI]  = smi_n_q & ~smi_n_s_i;  // falling edge
    set_d[REQ_NMI]  = nmi_s_i & ~nmi_q;      // rising edge
    set_d[REQ_INTR] = intr_i & if_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smi_n_q <= 1'b1;
      nmi_q   <= 1'b0;
      pend_q  <= '0;
    end else begin
      smi_n_q <= smi_n_s_i;
      nmi_q   <= nmi_s_i;
      pend_q  <= (pend_q & ~clr_i) | set_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/smm_state_fsm.sv
`timescale 1ns/1ps
module smm_state_fsm
  import smm_susp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hlt_i,
  input  logic             iret_i,
  input  logic             rsm_i,
  input  logic             smint_i,
  input  logic             susp_lo_i,
  input  logic [REQ_N-1:0] pend_i,
  output seq_state_e       state_o,
  output logic [REQ_N-1:0] disp_o
);
  seq_state_e       state_q, state_d, ret_q, ret_d;
  logic [REQ_N-1:0] disp_en, ready, disp;
  logic             irq_disp;

  always_comb begin
    unique case (state_q)
      ST_NORM, ST_ISR: disp_en = susp_lo_i ? '0 : '1;
      ST_HALT_N:       disp_en = '1;
      ST_HALT_S: begin
        disp_en          = '1;
        disp_en[REQ_SMI] = 1'b0;
      end
      default:         disp_en = '0;
    endcase
  end

  // fixed priority, lowest index wins
  always_comb begin
    logic seen;
    seen  = 1'b0;
    ready = pend_i & disp_en;
    for (int i = 0; i < int'(REQ_N); i++) begin
      disp[i] = ready[i] & ~seen;
      seen    = seen | ready[i];
    end
  end

  assign irq_disp = disp[REQ_NMI] | disp[REQ_INTR];

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    unique case (state_q)
      ST_NORM: begin
        if (susp_lo_i) begin
          state_d = ST_PSUSP_N;
          ret_d   = ST_NORM;
        end
        else if (disp[REQ_SMI]) state_d = ST_SMM;
        else if (irq_disp)      state_d = ST_ISR;
        else if (smint_i)       state_d = ST_SMM;
        else if (hlt_i)         state_d = ST_HALT_N;
      end
      ST_ISR: begin
        if (susp_lo_i) begin
          state_d = ST_PSUSP_N;
          ret_d   = ST_ISR;
        end
        else if (disp[REQ_SMI]) state_d = ST_SMM;
        else if (irq_disp)      state_d = ST_ISR;
        else if (iret_i)        state_d = ST_NORM;
      end
      ST_HALT_N: begin
        if (disp[REQ_SMI]) state_d = ST_SMM;
        else if (irq_disp) state_d = ST_ISR;
      end
      ST_PSUSP_N, ST_PSUSP_S: begin
        if (!susp_lo_i) state_d = ret_q;
      end
      ST_SMM: begin
        if (susp_lo_i) begin
          state_d = ST_PSUSP_S;
          ret_d   = ST_SMM;
        end
        else if (rsm_i) state_d = ST_NORM;
        else if (hlt_i) state_d = ST_HALT_S;
      end
      ST_HALT_S: begin
        if (irq_disp) state_d = ST_ISR_S;
      end
      ST_ISR_S: begin
        if (susp_lo_i) begin
          state_d = ST_PSUSP_S;
          ret_d   = ST_ISR_S;
        end
        else if (iret_i) state_d = ST_SMM;
      end
      default: state_d = ST_NORM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NORM;
      ret_q   <= ST_NORM;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
    end
  end

  assign state_o = state_q;
  assign disp_o  = disp;
endmodule

// File: rtl/smm_susp_seq.sv
`timescale 1ns/1ps
module smm_susp_seq
  import smm_susp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hlt_i,
  input  logic       iret_i,
  input  logic       rsm_i,
  input  logic       smint_i,
  input  logic       susp_ni,
  input  logic       smi_ni,
  input  logic       nmi_i,
  input  logic       intr_i,
  input  logic       if_i,
  output logic [2:0] state_o,
  output logic       suspa_no,
  output logic       smm_o,
  output logic       smi_disp_o,
  output logic       nmi_disp_o,
  output logic       intr_disp_o
);
  localparam int unsigned PIN_N = 3;
  localparam logic [PIN_N-1:0] PIN_RST = 3'b011; // {nmi, susp_n, smi_n}

  logic [PIN_N-1:0] pin_raw, pin_s;
  logic [REQ_N-1:0] pend, disp;
  seq_state_e       state;

  assign pin_raw = {nmi_i, susp_ni, smi_ni};

  smm_pin_sync #(
    .WIDTH  (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .q_o   (pin_s)
  );

  smm_req_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smi_n_s_i(pin_s[0]),
    .nmi_s_i  (pin_s[2]),
    .intr_i   (intr_i),
    .if_i     (if_i),
    .clr_i    (disp),
    .pend_o   (pend)
  );

  smm_state_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hlt_i    (hlt_i),
    .iret_i   (iret_i),
    .rsm_i    (rsm_i),
    .smint_i  (smint_i),
    .susp_lo_i(~pin_s[1]),
    .pend_i   (pend),
    .state_o  (state),
    .disp_o   (disp)
  );

  assign state_o     = state;
  assign suspa_no    = !(state inside {ST_HALT_N, ST_PSUSP_N, ST_HALT_S, ST_PSUSP_S});
  assign smm_o       = state inside {ST_SMM, ST_HALT_S, ST_PSUSP_S, ST_ISR_S};
  assign smi_disp_o  = disp[REQ_SMI];
  assign nmi_disp_o  = disp[REQ_NMI];
  assign intr_disp_o = disp[REQ_INTR];
endmodule

// File: rtl/smm_susp_seq_chk.sv
`timescale 1ns/1ps
module smm_susp_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] state_o,
  input logic       suspa_no,
  input logic       smm_o,
  input logic       smi_disp_o,
  input logic       nmi_disp_o,
  input logic       intr_disp_o
);
  assert_one_disp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({smi_disp_o, nmi_disp_o, intr_disp_o}));

  assert_ack_in_susp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 || state_o == 3'd3 || state_o == 3'd5 || state_o == 3'd6) |-> !suspa_no);

  assert_hold_in_psusp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 || state_o == 3'd6) |-> !(smi_disp_o || nmi_disp_o || intr_disp_o));

  assert_psusp_n_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3) |=> (state_o == 3'd3 || state_o == 3'd0 || state_o == 3'd1));

  assert_psusp_s_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd6) |=> (state_o == 3'd6 || state_o == 3'd4 || state_o == 3'd7));

  assert_smi_to_smm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_disp_o |=> (smm_o && state_o == 3'd4));

  assert_irq_to_isr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_disp_o || intr_disp_o) |=> (state_o == 3'd1 || state_o == 3'd7));
endmodule

bind smm_susp_seq smm_susp_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_o    (state_o),
  .suspa_no   (suspa_no),
  .smm_o      (smm_o),
  .smi_disp_o (smi_disp_o),
  .nmi_disp_o (nmi_disp_o),
  .intr_disp_o(intr_disp_o)
);

// File: tb/smm_susp_seq_tb_top.sv
`timescale 1ns/1ps
module smm_susp_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hlt = 0, iret = 0, rsm = 0, smint = 0;
  logic susp_n = 1, smi_n = 1, nmi = 0, intr = 0, ifl = 1;
  logic [2:0] state;
  logic suspa_n, smm, smi_d, nmi_d, intr_d;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  smm_susp_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hlt_i(hlt), .iret_i(iret), .rsm_i(rsm),
    .smint_i(smint), .susp_ni(susp_n), .smi_ni(smi_n), .nmi_i(nmi),
    .intr_i(intr), .if_i(ifl), .state_o(state), .suspa_no(suspa_n),
    .smm_o(smm), .smi_disp_o(smi_d), .nmi_disp_o(nmi_d), .intr_disp_o(intr_d)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic strobes(input string req, input int exp);
    chk(req, "strobes", int'({smi_d, nmi_d, intr_d}), exp);
  endtask

  task automatic pulse_instr(ref logic s);
    s = 1'b1;
    tick();
    s = 1'b0;
  endtask

  task automatic pulse_nmi();
    nmi = 1'b1; tick(); nmi = 1'b0; tick(3);
  endtask

  task automatic t_reset();
    chk("R1", "state", state, 0);
    chk("R1", "suspa_n", suspa_n, 1);
    chk("R1", "smm", smm, 0);
    strobes("R1", 0);
  endtask

  task automatic t_halt_nmi();
    pulse_instr(hlt);
    chk("R2", "halt state", state, 2);
    chk("R3", "suspa_n in halt", suspa_n, 0);
    nmi = 1'b1; tick(); nmi = 1'b0; tick(2);
    strobes("R11", 3'b010);
    chk("R11", "state before wake", state, 2);
    tick();
    chk("R5", "isr state", state, 1);
    chk("R3", "suspa_n in isr", suspa_n, 1);
    strobes("R9", 0);
    pulse_instr(iret);
    chk("R5", "iret to normal", state, 0);
  endtask

  task automatic t_halt_smi();
    pulse_instr(hlt);
    smi_n = 1'b0; tick(2); smi_n = 1'b1; tick();
    strobes("R4", 3'b100);
    tick();
    chk("R4", "smm state", state, 4);
    chk("R3", "smm flag", smm, 1);
    strobes("R4", 0);
    pulse_instr(rsm);
    chk("R10", "resume", state, 0);
    chk("R3", "smm flag off", smm, 0);
  endtask

  task automatic t_pin_susp_capture();
    susp_n = 1'b0; tick(3);
    chk("R6", "pin susp state", state, 3);
    chk("R3", "suspa_n pin", suspa_n, 0);
    ifl = 1'b1;
    intr = 1'b1; tick(); intr = 1'b0; tick();
    intr = 1'b1; tick(); intr = 1'b0; tick();
    pulse_nmi();
    pulse_nmi();
    smi_n = 1'b0; tick(2); smi_n = 1'b1; tick(3);
    smi_n = 1'b0; tick(2); smi_n = 1'b1; tick(3);
    chk("R7", "still suspended", state, 3);
    strobes("R7", 0);
    susp_n = 1'b1; tick(2);
    chk("R11", "release latency", state, 3);
    tick();
    chk("R6", "returned", state, 0);
    strobes("R9", 3'b100);
    tick();
    chk("R9", "smi first", state, 4);
    strobes("R7", 0);
    tick();
    strobes("R7", 0);
    pulse_instr(rsm);
    chk("R10", "rsm", state, 0);
    strobes("R9", 3'b010);
    tick();
    chk("R9", "isr after nmi", state, 1);
    strobes("R9", 3'b001);
    tick();
    strobes("R7", 0);
    chk("R7", "single occurrence", state, 1);
    pulse_instr(iret);
    chk("R5", "iret", state, 0);
  endtask

  task automatic t_intr_mask();
    ifl = 1'b0;
    intr = 1'b1; tick(); intr = 1'b0;
    strobes("R8", 0);
    tick();
    chk("R8", "masked state", state, 0);
    strobes("R8", 0);
    ifl = 1'b1;
    intr = 1'b1; tick(); intr = 1'b0;
    strobes("R8", 3'b001);
    tick();
    chk("R9", "isr", state, 1);
    susp_n = 1'b0; tick(3);
    chk("R6", "susp from isr", state, 3);
    susp_n = 1'b1; tick(3);
    chk("R6", "back to isr", state, 1);
    pulse_instr(iret);
    chk("R5", "iret", state, 0);
  endtask

  task automatic t_smm_defer();
    pulse_instr(smint);
    chk("R10", "smint state", state, 4);
    strobes("R10", 0);
    chk("R3", "smm flag", smm, 1);
    pulse_nmi();
    tick();
    chk("R7", "nmi deferred", state, 4);
    strobes("R7", 0);
    pulse_instr(rsm);
    chk("R7", "rsm", state, 0);
    strobes("R7", 3'b010);
    tick();
    chk("R9", "isr", state, 1);
    pulse_instr(iret);
  endtask

  task automatic t_smm_pin_susp();
    pulse_instr(smint);
    susp_n = 1'b0; tick(3);
    chk("R6", "smm pin susp", state, 6);
    chk("R3", "suspa_n", suspa_n, 0);
    chk("R3", "smm flag", smm, 1);
    susp_n = 1'b1; tick(3);
    chk("R6", "back to smm", state, 4);
    pulse_instr(rsm);
    chk("R10", "rsm", state, 0);
  endtask

  task automatic t_smm_halt_intr();
    pulse_instr(smint);
    pulse_instr(hlt);
    chk("R2", "halt in smm", state, 5);
    chk("R3", "suspa_n", suspa_n, 0);
    intr = 1'b1; tick(); intr = 1'b0;
    strobes("R11", 3'b001);
    tick();
    chk("R5", "isr in smm", state, 7);
    chk("R3", "smm flag", smm, 1);
    pulse_instr(iret);
    chk("R5", "iret to smm", state, 4);
    pulse_instr(rsm);
    chk("R10", "rsm", state, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_halt_nmi();
    t_halt_smi();
    t_pin_susp_capture();
    t_intr_mask();
    t_smm_defer();
    t_smm_pin_susp();
    t_smm_halt_intr();
    tick(2);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule